// File: doc/BRIEF.md
# Two-Speed Angle Combiner

This block merges a coarse shaft angle and a fine shaft angle into one extended-resolution position word. The fine shaft turns N times for each coarse revolution, where N is a programmable integer ratio. The coarse angle is scaled by N, and the scaled value shows which of the N fine cycles is current. That cycle number sits above the fine angle in the output word. This gives a 24-bit position: an 8-bit cycle index over the 16-bit fine angle.

The two channels are never perfectly aligned. A correction step therefore picks the cycle number most consistent with the fine reading, so the combined word does not jump backwards or skip when the fine angle wraps through zero. The block raises a sticky flag when the coarse channel disagrees with the fine channel by more than a quarter of a fine turn. A quarter fine turn equals 90 degrees divided by the ratio, in coarse degrees. A single-speed mode ignores the coarse input and passes the fine angle through.

A host loads the ratio and presents both angles with a sample strobe. The result and a valid pulse appear one clock later.

Top module: `two_speed_combiner`

## Requirements
- R1: The ratio register resets to 2. A write with a value from 2 to 255 is accepted. A write of 0 or 1 is ignored, and the previous ratio stays in effect for later samples.
- R2: On each sample, bits 15:0 of the result equal the fine angle presented with that sample.
- R3: In two-speed mode, bits 23:16 of the result equal ((coarse·N − fine + 32767) div 65536) mod N. Here coarse and fine are unsigned 16-bit values and N is the ratio. This is the integer part of coarse·N, moved by −1, 0 or +1 to the nearest cycle consistent with the fine angle.
- R4: The cycle index wraps modulo N. A fine angle just past zero, with the scaled coarse angle just below a full turn, gives index 0. A fine angle just below a full turn, with the scaled coarse angle just past zero, gives index N−1.
- R5: When the true position advances steadily and the coarse error stays small, the result equals the true position at every sample. The output is therefore monotonic across fine-cycle boundaries.
- R6: A two-speed sample sets the misalignment flag when d > 16384 or d < −16384. Here d is (fine − ((coarse·N) mod 65536)), wrapped to a signed 16-bit value. |d| = 16384 does not set the flag.
- R7: The misalignment flag stays set until the clear input is asserted. When a clear and a new misaligned sample occur in the same cycle, the flag ends set.
- R8: The valid output is a one-cycle pulse in the cycle after each sample strobe. The result holds its value between samples.
- R9: In single-speed mode the result is {8'h00, fine}, and the sample neither sets nor clears the misalignment flag.
- R10: After reset the result is 0, and valid and the misalignment flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 1 | Capture the angles this cycle |
| coarse_ang | input | 16 | Coarse shaft angle, full scale = one turn |
| fine_ang | input | 16 | Fine shaft angle, full scale = one turn |
| single_speed | input | 1 | 1 = pass the fine angle only |
| ratio_wr | input | 1 | Write strobe for the ratio register |
| ratio_in | input | 8 | Ratio value to write (2 to 255 accepted) |
| clr_misalign | input | 1 | Clear the sticky misalignment flag |
| pos_out | output | 24 | Combined position {cycle index, fine angle} |
| pos_valid | output | 1 | Pulse: pos_out updated |
| misalign | output | 1 | Sticky coarse/fine disagreement flag |

## Verification
A clear of the sticky flag and the detection of a new misalignment can land in the same cycle. The sweep provokes this by asserting the clear together with every sample. Fine offsets both inside and outside the quarter-turn window are driven across several ratios. After each such cycle the flag must equal the fresh misalignment result computed for that sample alone: set wins over clear, and an aligned sample leaves the flag clear. Separate directed steps check that the flag is sticky without a clear and that single-speed samples leave it alone.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int TSC_ANG_W = 16;
    localparam int TSC_IDX_W = 8;
    localparam int TSC_MIN_RATIO = 2;

    typedef enum logic [1:0] {
        ADJ_ZERO = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DN   = 2'd2
    } adj_e;
endpackage

// File: rtl/tsc_ratio_reg.sv
module tsc_ratio_reg
    import tsc_pkg::*;
#(
    parameter int IDX_W       = TSC_IDX_W,
    parameter int RESET_RATIO = TSC_MIN_RATIO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [IDX_W-1:0] din,
    output logic [IDX_W-1:0] ratio_q
);
    logic accept;

    assign accept = wr && (din >= IDX_W'(TSC_MIN_RATIO));

    always_ff @(posedge clk) begin
        if (rst)
            ratio_q <= IDX_W'(RESET_RATIO);
        else if (accept)
            ratio_q <= din;
    end
endmodule

// File: rtl/tsc_resolver.sv
module tsc_resolver
    import tsc_pkg::*;
#(
    parameter int ANG_W = TSC_ANG_W,
    parameter int IDX_W = TSC_IDX_W
) (
    input  logic [IDX_W-1:0] ratio,
    input  logic [ANG_W-1:0] coarse,
    input  logic [ANG_W-1:0] fine,
    output logic [IDX_W-1:0] idx,
    output logic             mis
);
    localparam int PROD_W = ANG_W + IDX_W;
    localparam int QTR    = 2 ** (ANG_W - 2);

    logic        [PROD_W-1:0] prod;
    logic        [IDX_W-1:0]  whole;
    logic        [ANG_W-1:0]  frac;
    logic signed [ANG_W-1:0]  diff;
    adj_e                     adj;

    assign prod  = PROD_W'(coarse) * PROD_W'(ratio);
    assign whole = prod[PROD_W-1:ANG_W];
    assign frac  = prod[ANG_W-1:0];
    assign diff  = $signed(fine - frac);

    // a wrapped difference whose sign disagrees with the raw order means
    // the fine angle has crossed zero relative to the scaled coarse angle
    always_comb begin
        if (diff >= 0 && fine < frac)
            adj = ADJ_UP;
        else if (diff < 0 && fine > frac)
            adj = ADJ_DN;
        else
            adj = ADJ_ZERO;
    end

    always_comb begin
        unique case (adj)
            ADJ_UP:  idx = (whole == ratio - IDX_W'(1)) ? '0 : whole + IDX_W'(1);
            ADJ_DN:  idx = (whole == '0) ? ratio - IDX_W'(1) : whole - IDX_W'(1);
            default: idx = whole;
        endcase
    end

    assign mis = (diff > QTR) || (diff < -QTR);
endmodule

// File: rtl/tsc_out_stage.sv
module tsc_out_stage
    import tsc_pkg::*;
#(
    parameter int ANG_W = TSC_ANG_W,
    parameter int IDX_W = TSC_IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sample,
    input  logic                   single,
    input  logic                   clr,
    input  logic [IDX_W-1:0]       idx,
    input  logic [ANG_W-1:0]       fine,
    input  logic                   mis,
    output logic [IDX_W+ANG_W-1:0] pos_q,
    output logic                   valid_q,
    output logic                   mis_q
);
    logic set_mis;

    assign set_mis = sample && !single && mis;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            valid_q <= 1'b0;
            mis_q   <= 1'b0;
        end else begin
            valid_q <= sample;
            if (sample)
                pos_q <= single ? {{IDX_W{1'b0}}, fine} : {idx, fine};
            if (set_mis)
                mis_q <= 1'b1;
            else if (clr)
                mis_q <= 1'b0;
        end
    end
endmodule

// File: rtl/two_speed_combiner.sv
module two_speed_combiner
    import tsc_pkg::*;
#(
    parameter int ANG_W       = TSC_ANG_W,
    parameter int IDX_W       = TSC_IDX_W,
    parameter int RESET_RATIO = TSC_MIN_RATIO
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sample,
    input  logic [ANG_W-1:0]       coarse_ang,
    input  logic [ANG_W-1:0]       fine_ang,
    input  logic                   single_speed,
    input  logic                   ratio_wr,
    input  logic [IDX_W-1:0]       ratio_in,
    input  logic                   clr_misalign,
    output logic [IDX_W+ANG_W-1:0] pos_out,
    output logic                   pos_valid,
    output logic                   misalign
);
    logic [IDX_W-1:0] ratio_q;
    logic [IDX_W-1:0] idx_c;
    logic             mis_c;

    tsc_ratio_reg #(.IDX_W(IDX_W), .RESET_RATIO(RESET_RATIO)) u_ratio (
        .clk     (clk),
        .rst     (rst),
        .wr      (ratio_wr),
        .din     (ratio_in),
        .ratio_q (ratio_q)
    );

    tsc_resolver #(.ANG_W(ANG_W), .IDX_W(IDX_W)) u_resolve (
        .ratio  (ratio_q),
        .coarse (coarse_ang),
        .fine   (fine_ang),
        .idx    (idx_c),
        .mis    (mis_c)
    );

    tsc_out_stage #(.ANG_W(ANG_W), .IDX_W(IDX_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample),
        .single  (single_speed),
        .clr     (clr_misalign),
        .idx     (idx_c),
        .fine    (fine_ang),
        .mis     (mis_c),
        .pos_q   (pos_out),
        .valid_q (pos_valid),
        .mis_q   (misalign)
    );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int ANG_W = 16,
    parameter int IDX_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sample,
    input logic                   single_speed,
    input logic                   clr_misalign,
    input logic [ANG_W-1:0]       fine_ang,
    input logic [IDX_W-1:0]       ratio_q,
    input logic [IDX_W+ANG_W-1:0] pos_out,
    input logic                   pos_valid,
    input logic                   misalign
);
    // R1
    ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_q >= IDX_W'(2));

    // R2
    fine_pass_chk: assert property (@(posedge clk) disable iff (rst)
        sample |=> pos_out[ANG_W-1:0] == $past(fine_ang));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        sample && !single_speed |=> pos_out[IDX_W+ANG_W-1:ANG_W] < $past(ratio_q));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        misalign && !clr_misalign |=> misalign);

    // R7
    clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        clr_misalign && !sample |=> !misalign);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sample |=> pos_valid);

    // R8
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sample |=> !pos_valid && $stable(pos_out));

    // R9
    single_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sample && single_speed |=> pos_out[IDX_W+ANG_W-1:ANG_W] == '0);

    // R9
    single_flag_chk: assert property (@(posedge clk) disable iff (rst)
        sample && single_speed && !clr_misalign |=> misalign == $past(misalign));
endmodule

bind two_speed_combiner tsc_checker #(.ANG_W(ANG_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample       (sample),
    .single_speed (single_speed),
    .clr_misalign (clr_misalign),
    .fine_ang     (fine_ang),
    .ratio_q      (ratio_q),
    .pos_out      (pos_out),
    .pos_valid    (pos_valid),
    .misalign     (misalign)
);

// File: tb/tb_two_speed_combiner.sv
module tb_two_speed_combiner;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample = 1'b0;
    logic [15:0] coarse_ang = '0;
    logic [15:0] fine_ang = '0;
    logic        single_speed = 1'b0;
    logic        ratio_wr = 1'b0;
    logic [7:0]  ratio_in = '0;
    logic        clr_misalign = 1'b0;
    logic [23:0] pos_out;
    logic        pos_valid;
    logic        misalign;

    int checks = 0;
    int errors = 0;
    int cur_ratio = 2;

    two_speed_combiner dut (
        .clk          (clk),
        .rst          (rst),
        .sample       (sample),
        .coarse_ang   (coarse_ang),
        .fine_ang     (fine_ang),
        .single_speed (single_speed),
        .ratio_wr     (ratio_wr),
        .ratio_in     (ratio_in),
        .clr_misalign (clr_misalign),
        .pos_out      (pos_out),
        .pos_valid    (pos_valid),
        .misalign     (misalign)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_idx(int n, int c, int f);
        int t;
        t = c * n - f + 32767 + n * 65536;
        return (t / 65536) % n;
    endfunction

    function automatic int exp_mis(int n, int c, int f);
        int d;
        d = f - ((c * n) % 65536);
        d = ((d % 65536) + 65536) % 65536;
        if (d >= 32768) d -= 65536;
        return (d > 16384 || d < -16384) ? 1 : 0;
    endfunction

    task automatic write_ratio(int v);
        @(negedge clk);
        ratio_wr = 1'b1;
        ratio_in = v[7:0];
        @(negedge clk);
        ratio_wr = 1'b0;
        if (v >= 2 && v <= 255) cur_ratio = v;
    endtask

    // drives one sample; outputs are read one cycle later at the negedge
    task automatic do_sample(int c, int f, logic single, logic clr);
        @(negedge clk);
        sample = 1'b1;
        coarse_ang = c[15:0];
        fine_ang = f[15:0];
        single_speed = single;
        clr_misalign = clr;
        @(negedge clk);
        sample = 1'b0;
        single_speed = 1'b0;
        clr_misalign = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_misalign = 1'b1;
        @(negedge clk);
        clr_misalign = 1'b0;
    endtask

    initial begin
        int offs[8] = '{0, 1, -1, 16384, -16384, 16385, -16385, 32768};
        int rats[4] = '{2, 3, 5, 255};
        int held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 pos_out", int'(pos_out), 0);
        check("R10 valid", int'(pos_valid), 0);
        check("R10 misalign", int'(misalign), 0);

        // R1 reset ratio is 2: coarse 0xC000 fine 0x8000 -> index 1
        do_sample(16'hC000, 16'h8000, 1'b0, 1'b1);
        check("R1 reset ratio", int'(pos_out), 24'h018000);
        write_ratio(5);
        do_sample(16'hC000, 16'h8000, 1'b0, 1'b1);
        check("R1 ratio 5", int'(pos_out[23:16]), 3);
        write_ratio(1);
        do_sample(16'hC000, 16'h8000, 1'b0, 1'b1);
        check("R1 reject 1", int'(pos_out[23:16]), 3);
        write_ratio(0);
        do_sample(16'hC000, 16'h8000, 1'b0, 1'b1);
        check("R1 reject 0", int'(pos_out[23:16]), 3);

        // R8 valid pulse and hold
        check("R8 valid high", int'(pos_valid), 1);
        held = int'(pos_out);
        @(negedge clk);
        check("R8 valid low", int'(pos_valid), 0);
        check("R8 hold", int'(pos_out), held);

        // R4 wrap upward and downward with ratio 3
        write_ratio(3);
        do_sample(65535, 5, 1'b0, 1'b1);
        check("R4 wrap up", int'(pos_out), 24'h000005);
        do_sample(0, 65530, 1'b0, 1'b1);
        check("R4 wrap down", int'(pos_out), 24'h02FFFA);

        // R6 exact quarter turn does not flag; one more does
        write_ratio(2);
        do_sample(0, 16384, 1'b0, 1'b1);
        check("R6 at limit", int'(misalign), 0);
        do_sample(0, 16385, 1'b0, 1'b1);
        check("R6 past limit", int'(misalign), 1);

        // R7 sticky without clear, then clear alone
        do_sample(0, 0, 1'b0, 1'b0);
        check("R7 sticky", int'(misalign), 1);
        // R9 single speed leaves flag set and zeroes index
        do_sample(16'h1234, 16'h9ABC, 1'b1, 1'b0);
        check("R9 single out", int'(pos_out), 24'h009ABC);
        check("R9 single flag", int'(misalign), 1);
        clear_flag();
        check("R7 cleared", int'(misalign), 0);
        do_sample(16'hF000, 16'h4000, 1'b1, 1'b0);
        check("R9 no set", int'(misalign), 0);

        // R3 R2 R6 R7 sweep: clear collides with every sample
        foreach (rats[ri]) begin
            write_ratio(rats[ri]);
            for (int c = 0; c <= 65535; c += 257) begin
                foreach (offs[oi]) begin
                    int f;
                    f = (((c * cur_ratio) % 65536) + offs[oi] + 65536) % 65536;
                    do_sample(c, f, 1'b0, 1'b1);
                    check("R3 index", int'(pos_out[23:16]), exp_idx(cur_ratio, c, f));
                    check("R2 fine", int'(pos_out[15:0]), f);
                    check("R7 collide", int'(misalign), exp_mis(cur_ratio, c, f));
                    check("R8 valid", int'(pos_valid), 1);
                end
            end
        end

        // R5 steady travel with small coarse error gives the true position
        write_ratio(3);
        clear_flag();
        for (int p = 0; p < 3 * 65536; p += 61) begin
            int c;
            int e;
            e = ((p / 61) % 3 - 1) * 40;
            c = ((p / 3) + e + 65536) % 65536;
            do_sample(c, p % 65536, 1'b0, 1'b0);
            check("R5 position", int'(pos_out), p);
        end
        check("R5 no flag", int'(misalign), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule